// File: doc/BRIEF.md
# Base Counter CSR Unit

This block keeps the three base event counters of one hardware thread: elapsed cycles, time and retired instructions. The core pulses a tick input once per core cycle and reports on a retire-count input how many instructions completed in that cycle. Both the cycle counter and the time counter follow the tick, so time runs at the core rate.

The pipeline asks for a counter value by presenting a 12-bit CSR address and the 5-bit source-register field of the read instruction. One cycle later the block returns either a valid result or an illegal-access flag. A retire count given in the same cycle as an instret read is folded into the value returned. The register width is a build parameter of 64 or 32 bits. In the 32-bit build the upper half of each counter has its own address. In the 64-bit build those addresses are decoded and then refused.

Top module: `base_ctr_csr`

## Requirements
- R1: Address 0xC00 reads the cycle counter, 0xC01 reads the time counter and 0xC02 reads the retired-instruction counter.
- R2: A request whose rs1 field is not zero is refused: rd_illegal_o rises, rd_valid_o stays low and rd_data_o is zero.
- R3: Each cycle with tick_i high advances the cycle counter and the time counter by exactly one. With tick_i low both hold their value. The two counters always hold equal values.
- R4: The retired-instruction counter grows by the value of ret_cnt_i in every cycle, including values above one.
- R5: An instret read returns the counter plus the ret_cnt_i value presented in the same cycle as the request.
- R6: Reset (rst_ni low, asynchronous) clears all counters and drives rd_valid_o, rd_illegal_o and rd_data_o to zero.
- R7: With XLEN=64 a read returns the whole counter. With XLEN=32 the addresses 0xC00 to 0xC02 return bits [31:0], and the addresses 0xC80 to 0xC82 return bits [63:32] of the same counters.
- R8: With XLEN=64 the addresses 0xC80, 0xC81 and 0xC82 are refused with rd_illegal_o.
- R9: Any address outside 0xC00 to 0xC02 and 0xC80 to 0xC82 is refused with rd_illegal_o.
- R10: The response appears in the cycle after the request, and a request may be issued in every cycle. A cycle with no request gives rd_valid_o and rd_illegal_o low and rd_data_o zero in the next cycle. A request gives exactly one of the two flags.
- R11: The counters are CTR_W bits wide (default 64) and wrap modulo 2^CTR_W without saturating. A counter narrower than the read width is zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Core-cycle tick for the cycle and time counters |
| ret_cnt_i | input | RET_W | Number of instructions retired this cycle |
| rd_req_i | input | 1 | Counter read request |
| rd_addr_i | input | 12 | CSR address of the request |
| rd_rs1_i | input | 5 | rs1 field of the read instruction |
| rd_data_o | output | XLEN | Counter value, zero unless valid |
| rd_valid_o | output | 1 | Response carries a counter value |
| rd_illegal_o | output | 1 | Request refused |

## Verification
The checker watches on every cycle that cycle and time step together with the tick and stay equal, and that instret grows by the retire count. It also checks that every request produces exactly one response flag a cycle later, that idle cycles produce an all-zero response, that a nonzero rs1 field is refused, and that the 64-bit build refuses the upper-half addresses. Only the bench scenarios can show that the returned numbers are right. That covers the address-to-counter mapping, the bypass of same-cycle retirements, the half-word selection in the 32-bit build and wrap-around, which the bench reaches through a narrow-counter build.

// File: rtl/ctr_csr_pkg.sv
package ctr_csr_pkg;

    localparam int unsigned NUM_CTR = 3;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned RS1_W   = 5;
    localparam int unsigned FULL_W  = 64;

    localparam int unsigned IDX_CYC = 0;
    localparam int unsigned IDX_TIM = 1;
    localparam int unsigned IDX_RET = 2;

    typedef enum logic [1:0] {
        SEL_CYC  = 2'd0,
        SEL_TIM  = 2'd1,
        SEL_RET  = 2'd2,
        SEL_NONE = 2'd3
    } ctr_sel_e;

    typedef struct packed {
        logic     legal;
        logic     hi;
        ctr_sel_e sel;
    } dec_t;

endpackage

// File: rtl/ctr_cell.sv
module ctr_cell #(
    parameter int unsigned W     = 64,
    parameter int unsigned INC_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [INC_W-1:0] inc_i,
    output logic [W-1:0]     val_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + W'(inc_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign val_o = st_q.cnt;

endmodule

// File: rtl/ctr_addr_dec.sv
module ctr_addr_dec
    import ctr_csr_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [RS1_W-1:0]  rs1_i,
    output dec_t              dec_o
);

    localparam bit HI_OK = (XLEN == 32);

    logic in_block;
    logic is_hi;
    logic zero_src;

    always_comb begin
        in_block = (addr_i[11:8] == 4'hC) && (addr_i[6:2] == 5'd0)
                   && (addr_i[1:0] != 2'd3);
        is_hi    = addr_i[7];
        zero_src = (rs1_i == '0);

        dec_o       = '0;
        dec_o.sel   = SEL_NONE;
        dec_o.hi    = is_hi;
        if (in_block) begin
            case (addr_i[1:0])
                2'd0:    dec_o.sel = SEL_CYC;
                2'd1:    dec_o.sel = SEL_TIM;
                default: dec_o.sel = SEL_RET;
            endcase
        end
        dec_o.legal = in_block && zero_src && (!is_hi || HI_OK);
    end

endmodule

// File: rtl/ctr_rd_mux.sv
module ctr_rd_mux
    import ctr_csr_pkg::*;
#(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned CTR_W = 64
) (
    input  logic [NUM_CTR-1:0][CTR_W-1:0] vals_i,
    input  ctr_sel_e                      sel_i,
    input  logic                          hi_i,
    output logic [XLEN-1:0]               data_o
);

    logic [CTR_W-1:0]  picked;
    logic [FULL_W-1:0] ext;
    logic [FULL_W-1:0] shifted;

    always_comb begin
        case (sel_i)
            SEL_CYC: picked = vals_i[IDX_CYC];
            SEL_TIM: picked = vals_i[IDX_TIM];
            SEL_RET: picked = vals_i[IDX_RET];
            default: picked = '0;
        endcase
        ext     = FULL_W'(picked);
        shifted = hi_i ? (ext >> 32) : ext;
        data_o  = XLEN'(shifted);
    end

endmodule

// File: rtl/base_ctr_csr.sv
module base_ctr_csr
    import ctr_csr_pkg::*;
#(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned CTR_W = 64,
    parameter int unsigned RET_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [RET_W-1:0]  ret_cnt_i,
    input  logic              rd_req_i,
    input  logic [11:0]       rd_addr_i,
    input  logic [4:0]        rd_rs1_i,
    output logic [XLEN-1:0]   rd_data_o,
    output logic              rd_valid_o,
    output logic              rd_illegal_o
);

    localparam int unsigned INC_W = (RET_W > 1) ? RET_W : 1;

    typedef struct packed {
        logic            valid;
        logic            illegal;
        logic [XLEN-1:0] data;
    } rsp_t;

    logic [NUM_CTR-1:0][INC_W-1:0] inc;
    logic [NUM_CTR-1:0][CTR_W-1:0] cur;
    logic [NUM_CTR-1:0][CTR_W-1:0] view;
    dec_t                          dec;
    logic [XLEN-1:0]               mux_data;
    rsp_t                          rsp_d, rsp_q;

    logic [CTR_W-1:0] cyc_now, tim_now, ret_now;

    assign inc[IDX_CYC] = INC_W'(tick_i);
    assign inc[IDX_TIM] = INC_W'(tick_i);
    assign inc[IDX_RET] = INC_W'(ret_cnt_i);

    generate
        for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
            ctr_cell #(
                .W     (CTR_W),
                .INC_W (INC_W)
            ) u_cell (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .inc_i  (inc[g]),
                .val_o  (cur[g])
            );
            if (g == IDX_RET) begin : g_fwd
                assign view[g] = cur[g] + CTR_W'(ret_cnt_i);
            end else begin : g_plain
                assign view[g] = cur[g];
            end
        end
    endgenerate

    ctr_addr_dec #(
        .XLEN (XLEN)
    ) u_dec (
        .addr_i (rd_addr_i),
        .rs1_i  (rd_rs1_i),
        .dec_o  (dec)
    );

    ctr_rd_mux #(
        .XLEN  (XLEN),
        .CTR_W (CTR_W)
    ) u_mux (
        .vals_i (view),
        .sel_i  (dec.sel),
        .hi_i   (dec.hi),
        .data_o (mux_data)
    );

    always_comb begin
        rsp_d = '0;
        if (rd_req_i) begin
            if (dec.legal) begin
                rsp_d.valid = 1'b1;
                rsp_d.data  = mux_data;
            end else begin
                rsp_d.illegal = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rsp_q <= '0;
        else         rsp_q <= rsp_d;
    end

    assign rd_data_o    = rsp_q.data;
    assign rd_valid_o   = rsp_q.valid;
    assign rd_illegal_o = rsp_q.illegal;

    assign cyc_now = cur[IDX_CYC];
    assign tim_now = cur[IDX_TIM];
    assign ret_now = cur[IDX_RET];

endmodule

// File: rtl/base_ctr_csr_chk.sv
module base_ctr_csr_chk #(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned CTR_W = 64,
    parameter int unsigned RET_W = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic [RET_W-1:0] ret_cnt_i,
    input logic             rd_req_i,
    input logic [11:0]      rd_addr_i,
    input logic [4:0]       rd_rs1_i,
    input logic [XLEN-1:0]  rd_data_o,
    input logic             rd_valid_o,
    input logic             rd_illegal_o,
    input logic [CTR_W-1:0] cyc_now,
    input logic [CTR_W-1:0] tim_now,
    input logic [CTR_W-1:0] ret_now
);

    // R3: both clock-driven counters step by the tick
    p_cyc_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> cyc_now == $past(cyc_now) + CTR_W'($past(tick_i)));

    // R3: time and cycle never diverge
    p_time_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tim_now == cyc_now);

    // R4: instret grows by the retire count
    p_ret_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> ret_now == $past(ret_now) + CTR_W'($past(ret_cnt_i)));

    // R10: one flag per request, next cycle
    p_one_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req_i |=> (rd_valid_o ^ rd_illegal_o));

    // R10: idle cycle gives an empty response
    p_idle_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_req_i |=> (!rd_valid_o && !rd_illegal_o && rd_data_o == '0));

    // R2: nonzero rs1 is refused
    p_rs1_refused_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req_i && rd_rs1_i != 5'd0) |=> (rd_illegal_o && rd_data_o == '0));

    generate
        if (XLEN == 64) begin : g_wide
            // R8: upper-half addresses refused in the wide build
            p_hi_refused_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (rd_req_i && rd_addr_i[11:7] == 5'b11001) |=> rd_illegal_o);
        end
    endgenerate

endmodule

bind base_ctr_csr base_ctr_csr_chk #(
    .XLEN  (XLEN),
    .CTR_W (CTR_W),
    .RET_W (RET_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .ret_cnt_i    (ret_cnt_i),
    .rd_req_i     (rd_req_i),
    .rd_addr_i    (rd_addr_i),
    .rd_rs1_i     (rd_rs1_i),
    .rd_data_o    (rd_data_o),
    .rd_valid_o   (rd_valid_o),
    .rd_illegal_o (rd_illegal_o),
    .cyc_now      (cyc_now),
    .tim_now      (tim_now),
    .ret_now      (ret_now)
);

// File: tb/base_ctr_csr_test.sv
module base_ctr_csr_test;

    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          req = 1'b0;
    logic [RW-1:0] rc = '0;
    logic [11:0]   addr = '0;
    logic [4:0]    rs1 = '0;

    logic [63:0] d64, dw;
    logic [31:0] d32;
    logic        v64, i64, v32, i32, vw, iw;

    int n_run = 0;
    int n_fail = 0;
    logic [63:0] m_cyc = '0;
    logic [63:0] m_ret = '0;

    always #10 clk = ~clk;

    base_ctr_csr #(.XLEN(64), .CTR_W(64), .RET_W(RW)) uut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ret_cnt_i(rc),
        .rd_req_i(req), .rd_addr_i(addr), .rd_rs1_i(rs1),
        .rd_data_o(d64), .rd_valid_o(v64), .rd_illegal_o(i64));

    base_ctr_csr #(.XLEN(32), .CTR_W(64), .RET_W(RW)) uut32 (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ret_cnt_i(rc),
        .rd_req_i(req), .rd_addr_i(addr), .rd_rs1_i(rs1),
        .rd_data_o(d32), .rd_valid_o(v32), .rd_illegal_o(i32));

    base_ctr_csr #(.XLEN(64), .CTR_W(8), .RET_W(RW)) uutw (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ret_cnt_i(rc),
        .rd_req_i(req), .rd_addr_i(addr), .rd_rs1_i(rs1),
        .rd_data_o(dw), .rd_valid_o(vw), .rd_illegal_o(iw));

    // expected {valid, illegal, data} from the requirement text
    function automatic logic [65:0] expect_rsp(int xl, int cw, logic rq,
            logic [11:0] a, logic [4:0] r, logic [RW-1:0] c);
        logic [63:0] v;
        logic        hit;
        logic        hi;
        if (!rq) return '0;
        hit = (a[11:8] == 4'hC) && (a[6:2] == 5'd0) && (a[1:0] != 2'd3);
        hi  = a[7];
        if (!hit || r != 5'd0 || (hi && xl == 64)) return {1'b0, 1'b1, 64'd0};
        v = (a[1:0] == 2'd2) ? m_ret + 64'(c) : m_cyc;
        if (cw < 64) v = v & ((64'd1 << cw) - 64'd1);
        if (xl == 32) v = hi ? {32'd0, v[63:32]} : {32'd0, v[31:0]};
        return {1'b1, 1'b0, v};
    endfunction

    task automatic chk(string tag, string who, logic [65:0] got, logic [65:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got v=%0b i=%0b d=%h expected v=%0b i=%0b d=%h",
                     tag, who, got[65], got[64], got[63:0], exp[65], exp[64], exp[63:0]);
        end
    endtask

    // one cycle: drive at negedge, response read at the next negedge
    task automatic step(string tag, logic rq, logic [11:0] a, logic [4:0] r,
                        logic t, logic [RW-1:0] c);
        logic [65:0] e64, e32, ew;
        req = rq; addr = a; rs1 = r; tick = t; rc = c;
        e64 = expect_rsp(64, 64, rq, a, r, c);
        e32 = expect_rsp(32, 64, rq, a, r, c);
        ew  = expect_rsp(64, 8, rq, a, r, c);
        @(posedge clk);
        m_cyc = m_cyc + 64'(t);
        m_ret = m_ret + 64'(c);
        @(negedge clk);
        chk(tag, "xlen64", {v64, i64, d64}, e64);
        chk(tag, "xlen32", {v32, i32, 32'd0, d32}, e32);
        chk(tag, "ctr8",   {vw, iw, dw}, ew);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R6", "xlen64", {v64, i64, d64}, '0);
        chk("R6", "xlen32", {v32, i32, 32'd0, d32}, '0);
        rst_n = 1'b1;
        step("R6", 1'b1, 12'hC00, 5'd0, 1'b0, '0);
        step("R6", 1'b1, 12'hC02, 5'd0, 1'b0, '0);
    endtask

    task automatic t_count();
        for (int k = 0; k < 10; k++) step("R3", 1'b0, 12'h000, 5'd0, 1'b1, '0);
        step("R1", 1'b1, 12'hC00, 5'd0, 1'b1, '0);
        step("R1", 1'b1, 12'hC01, 5'd0, 1'b1, '0);
    endtask

    task automatic t_hold();
        for (int k = 0; k < 5; k++) step("R3", 1'b0, 12'h000, 5'd0, 1'b0, '0);
        step("R3", 1'b1, 12'hC00, 5'd0, 1'b0, '0);
        step("R3", 1'b1, 12'hC01, 5'd0, 1'b0, '0);
    endtask

    task automatic t_retire();
        step("R4", 1'b0, 12'h000, 5'd0, 1'b1, 3'd1);
        step("R4", 1'b0, 12'h000, 5'd0, 1'b1, 3'd7);
        step("R4", 1'b1, 12'hC02, 5'd0, 1'b1, 3'd0);
        step("R5", 1'b1, 12'hC02, 5'd0, 1'b0, 3'd5);
        step("R5", 1'b1, 12'hC02, 5'd0, 1'b1, 3'd7);
        step("R5", 1'b1, 12'hC02, 5'd0, 1'b1, 3'd1);
    endtask

    task automatic t_rs1();
        step("R2", 1'b1, 12'hC00, 5'd1,  1'b1, 3'd2);
        step("R2", 1'b1, 12'hC02, 5'd31, 1'b1, 3'd2);
        step("R2", 1'b1, 12'hC01, 5'd4,  1'b0, '0);
        step("R2", 1'b1, 12'hC81, 5'd2,  1'b0, '0);
    endtask

    task automatic t_high();
        step("R7", 1'b1, 12'hC80, 5'd0, 1'b1, '0);
        step("R8", 1'b1, 12'hC81, 5'd0, 1'b1, 3'd3);
        step("R7", 1'b1, 12'hC82, 5'd0, 1'b1, 3'd4);
        step("R7", 1'b1, 12'hC00, 5'd0, 1'b1, '0);
        step("R7", 1'b1, 12'hC02, 5'd0, 1'b0, 3'd6);
    endtask

    task automatic t_bad();
        step("R9", 1'b1, 12'hC03, 5'd0, 1'b1, '0);
        step("R9", 1'b1, 12'hC83, 5'd0, 1'b1, '0);
        step("R9", 1'b1, 12'h000, 5'd0, 1'b1, '0);
        step("R9", 1'b1, 12'hB00, 5'd0, 1'b1, '0);
        step("R9", 1'b1, 12'hC04, 5'd0, 1'b1, '0);
        step("R9", 1'b1, 12'hC40, 5'd0, 1'b1, '0);
        step("R9", 1'b1, 12'h400, 5'd0, 1'b1, '0);
    endtask

    task automatic t_b2b();
        for (int k = 0; k < 24; k++) begin
            logic [11:0] a;
            case (k % 4)
                0: a = 12'hC00;
                1: a = 12'hC02;
                2: a = 12'hC01;
                default: a = 12'hC03;
            endcase
            step("R10", (k % 5) != 4, a, 5'd0, (k % 3) != 0, RW'(k % 8));
        end
    endtask

    task automatic t_wrap();
        for (int k = 0; k < 300; k++) step("R11", 1'b0, 12'h000, 5'd0, 1'b1, 3'd7);
        step("R11", 1'b1, 12'hC00, 5'd0, 1'b1, 3'd7);
        step("R11", 1'b1, 12'hC02, 5'd0, 1'b1, 3'd7);
        step("R11", 1'b1, 12'hC01, 5'd0, 1'b0, '0);
    endtask

    initial begin
        #(20 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_count();
        t_hold();
        t_retire();
        t_rs1();
        t_high();
        t_bad();
        t_b2b();
        t_wrap();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule